// File: doc/BRIEF.md
# Two-Key Register Write Gate

This block sits between a simple 32-bit register bus and a peripheral register file. It stops writes to the protected registers until software has stored two agreed 32-bit key words in two key registers that belong to the gate. While the gate is locked, protected writes are dropped without any error. Reads are never held back. Read data from the register file passes straight to the bus, and the gate supplies read data only for its own three registers.

Software opens the gate by writing the first magic word to key slot 0 at offset 0x6C and the second magic word to key slot 1 at offset 0x70. It closes the gate by writing any other value, normally zero, to either slot. A read-only status register at offset 0x74 shows the lock state, and the same state is also available as an output pin. The gate drives a single write-enable to the register file. The file takes address and write data directly from the bus.

Top module: `regwr_keygate`

## Requirements
- R1: After reset the gate is locked, both key slots read 0, the status register reads 0 and `file_we` is low.
- R2: Key slot 0 (offset 0x6C) and key slot 1 (offset 0x70) take every write, whatever the lock state. After the write's clock edge a read returns the written word.
- R3: The gate is open (`unlocked` = 1, status bit 0 = 1) exactly when slot 0 holds 0x83E70B13 and slot 1 holds 0x95A4F1E0. The state takes effect from the clock edge that stores the second matching key.
- R4: A write of any non-matching value, zero included, to either key slot locks the gate from that write's clock edge onward.
- R5: While the gate is locked, `file_we` stays low for every bus write.
- R6: While the gate is open, `file_we` equals `bus_we` in the same cycle for every address other than 0x6C, 0x70 and 0x74.
- R7: Writes to 0x6C, 0x70 or 0x74 never assert `file_we`.
- R8: For every address other than the three gate offsets, `bus_rdata` equals `file_rdata` in the same cycle, whatever the lock state.
- R9: The status register at 0x74 reads the lock state in bit 0 and zero in bits 31:1. Writes to it change neither the lock state nor any key slot.
- R10: The order of the two key writes does not matter. Slot 1 written before slot 0 opens the gate after the slot 0 write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle when high |
| bus_rdata | output | 32 | Read data for the current address |
| file_rdata | input | 32 | Read data from the protected register file |
| file_we | output | 1 | Write-enable to the protected register file |
| unlocked | output | 1 | High while both key slots match |

## Verification
A wrong key slot value shows up in two places on the next cycle. The slot reads back wrong on `bus_rdata`, and the lock state seen through `unlocked` and status bit 0 is wrong. The lock state also gates `file_we` in the same cycle as the bus write, so a gate stuck open or stuck shut causes a dropped or accepted protected write at once. The bench keeps a model of both slots and compares `file_we`, `bus_rdata` and `unlocked` on every cycle of a random mix of key, status and file accesses. The random mix is weighted toward the magic words. Directed runs cover both key orders and relocking with zero.

// File: rtl/keygate_pkg.sv
package keygate_pkg;

   // Gate-owned register offsets (byte addresses).
   localparam int unsigned KG_OFS_KEY0 = 32'h6C;
   localparam int unsigned KG_OFS_KEY1 = 32'h70;
   localparam int unsigned KG_OFS_STAT = 32'h74;

   // Magic words that open the gate.
   localparam logic [31:0] KG_MAGIC0 = 32'h83E7_0B13;
   localparam logic [31:0] KG_MAGIC1 = 32'h95A4_F1E0;

   // Select vector for the gate's own address space.
   typedef struct packed {
      logic key0;
      logic key1;
      logic stat;
   } kg_sel_t;

   function automatic logic kg_any(input kg_sel_t s);
      return s.key0 | s.key1 | s.stat;
   endfunction

endpackage

// File: rtl/keygate_keyreg.sv
module keygate_keyreg #(
   parameter int unsigned DATA_W    = 32,
   parameter logic [DATA_W-1:0] KEY_VAL = '0,
   parameter bit          KEEP_WORD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic              match,
   output logic [DATA_W-1:0] rd_val
);

   generate
      if (KEEP_WORD) begin : g_word
         // Full word kept, so the slot reads back exactly what was written.
         logic [DATA_W-1:0] word_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  word_q <= '0;
            else if (wr) word_q <= wdata;
         end
         assign match  = (word_q == KEY_VAL);
         assign rd_val = word_q;
      end else begin : g_flag
         // Only the comparison result is kept. This costs one flop.
         logic hit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  hit_q <= 1'b0;
            else if (wr) hit_q <= (wdata == KEY_VAL);
         end
         assign match  = hit_q;
         assign rd_val = hit_q ? KEY_VAL : '0;
      end
   endgenerate

   // R2/R4: after a write, the slot's match flag follows the written word.
   a_r4_slot_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (match == ($past(wdata) == KEY_VAL)));

   // R1: a slot only leaves the reset value through a write.
   a_r1_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(rd_val));

endmodule

// File: rtl/keygate_decode.sv
module keygate_decode
   import keygate_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned OFS_KEY0 = KG_OFS_KEY0,
   parameter int unsigned OFS_KEY1 = KG_OFS_KEY1,
   parameter int unsigned OFS_STAT = KG_OFS_STAT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   output kg_sel_t           sel,
   output logic              sel_any
);

   localparam logic [ADDR_W-1:0] A_K0 = ADDR_W'(OFS_KEY0);
   localparam logic [ADDR_W-1:0] A_K1 = ADDR_W'(OFS_KEY1);
   localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(OFS_STAT);

   always_comb begin
      sel.key0 = (addr == A_K0);
      sel.key1 = (addr == A_K1);
      sel.stat = (addr == A_ST);
      sel_any  = kg_any(sel);
   end

   // R7: at most one gate register is selected at a time.
   a_r7_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sel.key0, sel.key1, sel.stat}));

endmodule

// File: rtl/keygate_rmux.sv
module keygate_rmux
   import keygate_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  kg_sel_t           sel,
   input  logic [DATA_W-1:0] key0_rd,
   input  logic [DATA_W-1:0] key1_rd,
   input  logic              open_st,
   input  logic [DATA_W-1:0] file_rdata,
   output logic [DATA_W-1:0] rdata
);

   localparam logic [DATA_W-1:0] STAT_ZERO = '0;

   always_comb begin
      unique case (1'b1)
         sel.key0: rdata = key0_rd;
         sel.key1: rdata = key1_rd;
         sel.stat: rdata = {STAT_ZERO[DATA_W-1:1], open_st};
         default:  rdata = file_rdata;
      endcase
   end

endmodule

// File: rtl/regwr_keygate.sv
module regwr_keygate
   import keygate_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned OFS_KEY0  = KG_OFS_KEY0,
   parameter int unsigned OFS_KEY1  = KG_OFS_KEY1,
   parameter int unsigned OFS_STAT  = KG_OFS_STAT,
   parameter logic [31:0] MAGIC0    = KG_MAGIC0,
   parameter logic [31:0] MAGIC1    = KG_MAGIC1,
   parameter bit          KEEP_WORD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [DATA_W-1:0] file_rdata,
   output logic              file_we,
   output logic              unlocked
);

   localparam logic [DATA_W-1:0] KEY0_W = DATA_W'(MAGIC0);
   localparam logic [DATA_W-1:0] KEY1_W = DATA_W'(MAGIC1);
   localparam int unsigned       ADDR_SPAN = 1 << ADDR_W;

   generate
      if (DATA_W < 32) begin : g_bad_w
         $error("keygate: DATA_W must hold a full 32-bit key");
      end
      if (OFS_KEY0 >= ADDR_SPAN || OFS_KEY1 >= ADDR_SPAN || OFS_STAT >= ADDR_SPAN) begin : g_bad_a
         $error("keygate: gate offsets do not fit in ADDR_W");
      end
      if (OFS_KEY0 == OFS_KEY1 || OFS_KEY0 == OFS_STAT || OFS_KEY1 == OFS_STAT) begin : g_bad_o
         $error("keygate: gate offsets must be distinct");
      end
   endgenerate

   kg_sel_t           sel;
   logic              sel_any;
   logic              m0, m1;
   logic [DATA_W-1:0] k0_rd, k1_rd;

   keygate_decode #(
      .ADDR_W(ADDR_W), .OFS_KEY0(OFS_KEY0), .OFS_KEY1(OFS_KEY1), .OFS_STAT(OFS_STAT)
   ) u_dec (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .sel(sel), .sel_any(sel_any)
   );

   keygate_keyreg #(.DATA_W(DATA_W), .KEY_VAL(KEY0_W), .KEEP_WORD(KEEP_WORD)) u_key0 (
      .clk(clk), .rst_n(rst_n), .wr(bus_we & sel.key0), .wdata(bus_wdata),
      .match(m0), .rd_val(k0_rd)
   );

   keygate_keyreg #(.DATA_W(DATA_W), .KEY_VAL(KEY1_W), .KEEP_WORD(KEEP_WORD)) u_key1 (
      .clk(clk), .rst_n(rst_n), .wr(bus_we & sel.key1), .wdata(bus_wdata),
      .match(m1), .rd_val(k1_rd)
   );

   assign unlocked = m0 & m1;
   assign file_we  = bus_we & ~sel_any & unlocked;

   keygate_rmux #(.DATA_W(DATA_W)) u_rmux (
      .sel(sel), .key0_rd(k0_rd), .key1_rd(k1_rd), .open_st(unlocked),
      .file_rdata(file_rdata), .rdata(bus_rdata)
   );

   // R5: no protected write gets through a locked gate.
   a_r5_locked_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked |-> !file_we);

   // R7: gate offsets never reach the register file.
   a_r7_gate_offsets: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(OFS_KEY0) || bus_addr == ADDR_W'(OFS_KEY1) ||
       bus_addr == ADDR_W'(OFS_STAT)) |-> !file_we);

   // R4: a wrong word in either slot locks on the next cycle.
   a_r4_relock: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && ((bus_addr == ADDR_W'(OFS_KEY0) && bus_wdata != KEY0_W) ||
                  (bus_addr == ADDR_W'(OFS_KEY1) && bus_wdata != KEY1_W))) |=> !unlocked);

   // R9: writing the status register leaves the lock state alone.
   a_r9_status_ro: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(OFS_STAT)) |=> $stable(unlocked));

   // R3: the lock state changes only on a key write.
   a_r3_change_on_key: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && (bus_addr == ADDR_W'(OFS_KEY0) || bus_addr == ADDR_W'(OFS_KEY1)))
      |=> $stable(unlocked));

endmodule

// File: tb/sim_regwr_keygate.sv
module sim_regwr_keygate;

   localparam logic [7:0]  A_K0 = 8'h6C;
   localparam logic [7:0]  A_K1 = 8'h70;
   localparam logic [7:0]  A_ST = 8'h74;
   localparam logic [31:0] MG0  = 32'h83E7_0B13;
   localparam logic [31:0] MG1  = 32'h95A4_F1E0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_rdata;
   logic [31:0] file_rdata = '0;
   logic        file_we;
   logic        unlocked;

   int unsigned n_chk = 0;
   int unsigned n_bad = 0;
   logic [31:0] mk0 = '0, mk1 = '0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   regwr_keygate u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_rdata(bus_rdata), .file_rdata(file_rdata),
      .file_we(file_we), .unlocked(unlocked)
   );

   function automatic bit m_open();
      return (mk0 == MG0) && (mk1 == MG1);
   endfunction

   function automatic logic [31:0] m_rdata(input logic [7:0] a, input logic [31:0] frd);
      if (a == A_K0) return mk0;
      if (a == A_K1) return mk1;
      if (a == A_ST) return {31'd0, m_open()};
      return frd;
   endfunction

   function automatic bit m_we(input logic [7:0] a, input logic we);
      return we && m_open() && a != A_K0 && a != A_K1 && a != A_ST;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // One bus cycle: drive at negedge, check combinational outputs, commit at posedge.
   task automatic bus_op(input logic [7:0] a, input logic [31:0] d, input logic we,
                         input logic [31:0] frd);
      string rtag;
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = we; file_rdata = frd;
      #1;
      if (a == A_K0 || a == A_K1) rtag = "R2 key read";
      else if (a == A_ST)         rtag = "R9 status read";
      else                        rtag = "R8 file read";
      check(rtag, bus_rdata, m_rdata(a, frd));
      if (a == A_K0 || a == A_K1 || a == A_ST)
         check("R7 gate write", {31'd0, file_we}, {31'd0, m_we(a, we)});
      else if (m_open())
         check("R6 open write", {31'd0, file_we}, {31'd0, m_we(a, we)});
      else
         check("R5 locked write", {31'd0, file_we}, {31'd0, m_we(a, we)});
      check("R3 lock pin", {31'd0, unlocked}, {31'd0, m_open()});
      @(posedge clk);
      if (we && a == A_K0) mk0 = d;
      if (we && a == A_K1) mk1 = d;
   endtask

   task automatic expect_open(input string tag, input bit e);
      @(negedge clk);
      bus_we = 1'b0;
      #1;
      check(tag, {31'd0, unlocked}, {31'd0, e});
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;

      // R1 reset state
      bus_op(A_K0, 32'h0, 1'b0, 32'h0);
      check("R1 reset key0", bus_rdata, 32'h0);
      bus_op(A_ST, 32'h0, 1'b0, 32'h0);
      check("R1 reset status", bus_rdata, 32'h0);
      check("R1 reset file_we", {31'd0, file_we}, 32'h0);

      // R5: locked write dropped
      bus_op(8'h10, 32'hDEAD_BEEF, 1'b1, 32'h1234);

      // R3 unlock in document order
      bus_op(A_K0, MG0, 1'b1, 32'h0);
      expect_open("R3 half key stays locked", 1'b0);
      bus_op(A_K1, MG1, 1'b1, 32'h0);
      expect_open("R3 both keys open", 1'b1);
      bus_op(8'h20, 32'hCAFE_F00D, 1'b1, 32'h55);   // R6
      bus_op(A_ST, 32'h0, 1'b1, 32'h0);             // R9 status write ignored
      expect_open("R9 status write no effect", 1'b1);
      bus_op(A_ST, 32'h0, 1'b0, 32'h0);
      check("R9 status bit", bus_rdata, 32'h1);

      // R4 relock with zero
      bus_op(A_K1, 32'h0, 1'b1, 32'h0);
      expect_open("R4 zero relocks", 1'b0);
      bus_op(8'h20, 32'h1, 1'b1, 32'h0);             // R5 dropped again
      bus_op(A_K0, 32'h0, 1'b1, 32'h0);

      // R10 reverse order
      bus_op(A_K1, MG1, 1'b1, 32'h0);
      expect_open("R10 key1 first stays locked", 1'b0);
      bus_op(A_K0, MG0, 1'b1, 32'h0);
      expect_open("R10 reverse order opens", 1'b1);
      bus_op(A_K0, MG0 ^ 32'h1, 1'b1, 32'h0);
      expect_open("R4 near-miss relocks", 1'b0);

      // Random mix
      for (int i = 0; i < 600; i++) begin
         logic [7:0]  a;
         logic [31:0] d;
         int unsigned sa = $urandom_range(0, 5);
         int unsigned sd = $urandom_range(0, 3);
         case (sa)
            0: a = A_K0;
            1: a = A_K1;
            2: a = A_ST;
            default: a = 8'($urandom);
         endcase
         case (sd)
            0: d = MG0;
            1: d = MG1;
            2: d = 32'h0;
            default: d = $urandom;
         endcase
         if (a == A_K0 && $urandom_range(0, 1) == 1) d = MG0;
         if (a == A_K1 && $urandom_range(0, 1) == 1) d = MG1;
         bus_op(a, d, 1'($urandom_range(0, 1)), $urandom);
      end

      done = 1'b1;
   end

   initial begin : watchdog
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
         end
      join_any
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule